// File: doc/BRIEF.md
# Parallel Through-Silicon-Via Session Test Controller

This controller runs a pre-bond test of a small group of through-silicon vias that share one probe contact. It does not test each via alone. It runs a fixed list of sessions. Each session enables several vias at once, waits for the charge capacitor to fill, and then reads a single comparator that says whether the whole group behaved. The charge wait shortens as more vias conduct in parallel, so it is looked up from the session size.

After the last session the controller combines the results. A passing session clears every via it contains. A via is reported faulty only when every session that contains it failed. The default table gives each via two sessions that overlap in that via alone, so any single faulty via can be located. When more vias are flagged than the design target allows, an overflow flag warns that the map may be ambiguous.

The session table, the charge wait for each session size, the resolution bound and the fault target are all parameters. A start pulse launches a run. Busy covers the whole run, a one-cycle done pulse ends it, and the fault map holds its value until the next start.

Top module: `tsv_session_ctrl`

## Requirements
- R1: While reset is held, and after it is released, busy, done, via_en, fault_map and overflow are all zero.
- R2: A start seen while idle raises busy on the next cycle. Busy stays high until done. A start seen while busy has no effect on timing or result.
- R3: Non-empty sessions run in ascending table index. While a session runs, via_en equals its table mask exactly, where bit i is via i+1.
- R4: For a session of q vias, via_en is held for W(q)+1 cycles: W(q) charge cycles plus one sample cycle. The default W is 80, 53, 42 and 38 cycles for q = 1, 2, 3 and 4. The default run of four three-via sessions takes 178 cycles from the start edge to the done cycle.
- R5: After each sample cycle, via_en is all zero for exactly one cycle before the next session begins. Enables never switch directly from one session mask to another.
- R6: Empty table entries take no cycles. A table with only empty entries reaches done on the second cycle after start.
- R7: cmp_pass high in the sample cycle marks every via of that session good. At the end, fault_map bit i is 1 only if via i+1 is in some session and no session containing it passed.
- R8: overflow is 1 exactly when fault_map has more than MAX_FAULT bits set (default 1).
- R9: done lasts one cycle. fault_map and overflow are valid with done and hold until the next start, which clears them.
- R10: via_en never has more than RES bits set (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a test run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| via_en | output | N_VIA | Gated scan flip-flop enable per via |
| cmp_pass | input | 1 | Charge comparator verdict, 1 = pass |
| fault_map | output | N_VIA | Resolved faulty vias, bit i = via i+1 |
| overflow | output | 1 | More faulty vias than MAX_FAULT |

## Verification
The hardest case to reach from the ports is a map where overlapping failures make healthy vias look faulty. Only a particular mix of failing sessions produces it. The bench models the comparator as "no injected fault among the enabled vias". It then injects pairs of faults that spread across every session of the default table, so that the overflow path and the all-faulty map are driven by real session outcomes. A second table with empty entries at the start, middle and end, and sessions of one, two and four vias, reaches the skip logic and the other charge waits. An all-empty table reaches the path that goes straight from start to resolution.

// File: rtl/tsv_sess_pkg.sv
package tsv_sess_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHARGE,
        ST_SAMPLE,
        ST_GAP,
        ST_RESOLVE,
        ST_DONE
    } tsv_state_e;

endpackage

// File: rtl/tsv_sess_pick.sv
// Finds the first non-empty session at or after a base index.
module tsv_sess_pick #(
    parameter int N_VIA  = 6,
    parameter int N_SESS = 4,
    parameter int IW     = 3,
    parameter logic [N_SESS-1:0][N_VIA-1:0] TAB = '0
) (
    input  logic [IW-1:0]    base,
    output logic [IW-1:0]    pick,
    output logic [N_VIA-1:0] mask,
    output logic             found
);
    always_comb begin
        pick  = '0;
        mask  = '0;
        found = 1'b0;
        for (int i = N_SESS - 1; i >= 0; i--) begin
            if (IW'(i) >= base && |TAB[i]) begin
                pick  = IW'(i);
                mask  = TAB[i];
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tsv_charge_timer.sv
// Down-counter for the charge wait; expired when it reaches zero.
module tsv_charge_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/tsv_fault_resolve.sv
// A via is faulty if it belongs to a session and no session containing it passed.
module tsv_fault_resolve #(
    parameter int N_VIA     = 6,
    parameter int N_SESS    = 4,
    parameter int MAX_FAULT = 1,
    parameter logic [N_SESS-1:0][N_VIA-1:0] TAB = '0
) (
    input  logic [N_VIA-1:0] cleared,
    output logic [N_VIA-1:0] fault,
    output logic             ovf
);
    logic [N_VIA-1:0] members;

    always_comb begin
        members = '0;
        for (int i = 0; i < N_SESS; i++)
            members = members | TAB[i];
        fault = members & ~cleared;
        ovf   = ($countones(fault) > MAX_FAULT);
    end
endmodule

// File: rtl/tsv_session_ctrl.sv
module tsv_session_ctrl
    import tsv_sess_pkg::*;
#(
    parameter int N_VIA     = 6,
    parameter int N_SESS    = 4,
    parameter int RES       = 4,
    parameter int MAX_FAULT = 1,
    parameter int CNT_W     = 8,
    parameter logic [N_SESS-1:0][N_VIA-1:0] SESS_TAB =
        {6'b110100, 6'b101010, 6'b011001, 6'b000111},
    parameter logic [RES-1:0][CNT_W-1:0] WAIT_TAB =
        {8'd38, 8'd42, 8'd53, 8'd80}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [N_VIA-1:0] via_en,
    input  logic             cmp_pass,
    output logic [N_VIA-1:0] fault_map,
    output logic             overflow
);
    localparam int IW = $clog2(N_SESS + 1);

    tsv_state_e        state, state_nx;
    logic [IW-1:0]     sess_idx;
    logic [N_VIA-1:0]  cur_mask;
    logic [N_VIA-1:0]  pass_acc;
    logic [IW-1:0]     search_base;
    logic [IW-1:0]     pick_idx;
    logic [N_VIA-1:0]  pick_mask;
    logic              pick_found;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              expired;
    logic [N_VIA-1:0]  res_fault;
    logic              res_ovf;

    assign search_base = (state == ST_GAP) ? sess_idx + IW'(1) : '0;

    tsv_sess_pick #(
        .N_VIA (N_VIA),
        .N_SESS(N_SESS),
        .IW    (IW),
        .TAB   (SESS_TAB)
    ) u_pick (
        .base (search_base),
        .pick (pick_idx),
        .mask (pick_mask),
        .found(pick_found)
    );

    always_comb begin
        timer_val = '0;
        for (int k = 0; k < RES; k++)
            if ($countones(pick_mask) == k + 1)
                timer_val = WAIT_TAB[k] - CNT_W'(1);
    end

    assign timer_load = pick_found &&
                        ((state == ST_IDLE && start) || state == ST_GAP);

    tsv_charge_timer #(.CW(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(timer_val),
        .expired (expired)
    );

    tsv_fault_resolve #(
        .N_VIA    (N_VIA),
        .N_SESS   (N_SESS),
        .MAX_FAULT(MAX_FAULT),
        .TAB      (SESS_TAB)
    ) u_resolve (
        .cleared(pass_acc),
        .fault  (res_fault),
        .ovf    (res_ovf)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = pick_found ? ST_CHARGE : ST_RESOLVE;
            ST_CHARGE:  if (expired) state_nx = ST_SAMPLE;
            ST_SAMPLE:  state_nx = ST_GAP;
            ST_GAP:     state_nx = pick_found ? ST_CHARGE : ST_RESOLVE;
            ST_RESOLVE: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // session bookkeeping and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_idx  <= '0;
            cur_mask  <= '0;
            pass_acc  <= '0;
            fault_map <= '0;
            overflow  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                pass_acc  <= '0;
                fault_map <= '0;
                overflow  <= 1'b0;
            end
            if (timer_load) begin
                sess_idx <= pick_idx;
                cur_mask <= pick_mask;
            end
            if (state == ST_SAMPLE && cmp_pass)
                pass_acc <= pass_acc | cur_mask;
            if (state == ST_RESOLVE) begin
                fault_map <= res_fault;
                overflow  <= res_ovf;
            end
        end
    end

    // outputs
    always_comb begin
        via_en = '0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_CHARGE:  via_en = cur_mask;
            ST_SAMPLE:  via_en = cur_mask;
            ST_GAP:     ;
            ST_RESOLVE: ;
            ST_DONE:    done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsv_session_ctrl_chk.sv
module tsv_session_ctrl_chk #(
    parameter int N_VIA     = 6,
    parameter int RES       = 4,
    parameter int MAX_FAULT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [N_VIA-1:0] via_en,
    input logic [N_VIA-1:0] fault_map,
    input logic             overflow
);
    // R10
    res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(via_en) <= RES);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fault_map) && $stable(overflow)));

    // R5
    no_direct_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|via_en) && (|$past(via_en))) |-> (via_en == $past(via_en)));

    // R2
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    overflow_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (overflow == ($countones(fault_map) > MAX_FAULT)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (via_en == '0));
endmodule

bind tsv_session_ctrl tsv_session_ctrl_chk #(
    .N_VIA    (N_VIA),
    .RES      (RES),
    .MAX_FAULT(MAX_FAULT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .via_en   (via_en),
    .fault_map(fault_map),
    .overflow (overflow)
);

// File: tb/tsv_session_ctrl_test.sv
`timescale 1ns/1ps
module tsv_session_ctrl_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       start_v [3];
    logic [5:0] inj     [3];
    logic [5:0] en      [3];
    logic [5:0] fmap    [3];
    logic       busy    [3];
    logic       done    [3];
    logic       ovf     [3];
    logic       cmp     [3];

    int checks = 0;
    int errors = 0;
    int cyc_g, done_g;
    logic [5:0] first_g;

    for (genvar k = 0; k < 3; k++) begin : g_cmp
        assign cmp[k] = ((en[k] & inj[k]) == 6'b0);
    end

    tsv_session_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start_v[0]), .busy(busy[0]), .done(done[0]),
        .via_en(en[0]), .cmp_pass(cmp[0]), .fault_map(fmap[0]), .overflow(ovf[0]));

    tsv_session_ctrl #(
        .N_SESS(7),
        .SESS_TAB({6'b000000, 6'b101011, 6'b111100, 6'b000000,
                   6'b000110, 6'b000001, 6'b000000})
    ) uut_skip (
        .clk(clk), .rst_n(rst_n), .start(start_v[1]), .busy(busy[1]), .done(done[1]),
        .via_en(en[1]), .cmp_pass(cmp[1]), .fault_map(fmap[1]), .overflow(ovf[1]));

    tsv_session_ctrl #(
        .N_SESS(2),
        .SESS_TAB({6'b000000, 6'b000000})
    ) uut_void (
        .clk(clk), .rst_n(rst_n), .start(start_v[2]), .busy(busy[2]), .done(done[2]),
        .via_en(en[2]), .cmp_pass(cmp[2]), .fault_map(fmap[2]), .overflow(ovf[2]));

    // {injected faults, expected map, expected overflow} for the default table
    localparam int NVEC = 7;
    localparam logic [12:0] VEC [NVEC] = '{
        {6'b000000, 6'b000000, 1'b0},
        {6'b000001, 6'b000001, 1'b0},
        {6'b100000, 6'b100000, 1'b0},
        {6'b001000, 6'b001000, 1'b0},
        {6'b100001, 6'b111111, 1'b1},
        {6'b000011, 6'b001011, 1'b1},
        {6'b111111, 6'b111111, 1'b1}
    };
    localparam logic [5:0] EXP_MASK [4] = '{6'b000111, 6'b011001, 6'b101010, 6'b110100};

    function automatic int wait_for(input int q);
        case (q)
            1: return 80;
            2: return 53;
            3: return 42;
            4: return 38;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int s, input logic [5:0] f, input bit seg, input int mid_start);
        logic [5:0] prev, e;
        int run_len, gap, idx;
        bit fin;
        inj[s] = f;
        @(negedge clk); start_v[s] = 1'b1;
        @(negedge clk); start_v[s] = 1'b0;
        chk(busy[s] == 1'b1, "R2", "busy after start", int'(busy[s]), 1);
        chk(fmap[s] == 6'b0, "R9", "map cleared by start", int'(fmap[s]), 0);
        cyc_g = 0; done_g = 0; prev = '0; run_len = 0; gap = 0; idx = 0; fin = 1'b0;
        first_g = en[s];
        while (!fin && cyc_g < 2000) begin
            cyc_g++;
            start_v[s] = (cyc_g == mid_start);
            e = en[s];
            if (seg) begin
                if (e != 6'b0) begin
                    if (e == prev) run_len++;
                    else begin
                        if (idx > 0) chk(gap == 1, "R5", "zero-enable gap length", gap, 1);
                        if (idx < 4) chk(e == EXP_MASK[idx], "R3", "session mask", int'(e), int'(EXP_MASK[idx]));
                        chk($countones(e) <= 4, "R10", "enabled via count", $countones(e), 4);
                        run_len = 1; gap = 0;
                    end
                end else begin
                    if (prev != 6'b0) begin
                        chk(run_len == wait_for($countones(prev)) + 1, "R4", "enable hold cycles",
                            run_len, wait_for($countones(prev)) + 1);
                        idx++;
                    end
                    gap++;
                end
                prev = e;
            end
            if (done[s]) begin done_g++; fin = 1'b1; end
            @(negedge clk);
        end
        start_v[s] = 1'b0;
        if (seg) chk(idx == 4, "R3", "sessions run", idx, 4);
        chk(done[s] == 1'b0, "R9", "done is one cycle", int'(done[s]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog (all requirements): run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] held;
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin start_v[k] = 1'b0; inj[k] = '0; end
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(!busy[k] && !done[k], "R1", "busy/done in reset", int'(busy[k]), 0);
            chk(en[k] == 6'b0 && fmap[k] == 6'b0 && !ovf[k], "R1", "enables/map in reset",
                int'(en[k] | fmap[k]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy[0] && en[0] == 6'b0, "R1", "idle after reset", int'(en[0]), 0);

        // table-driven runs on the default network
        for (int v = 0; v < NVEC; v++) begin
            run(0, VEC[v][12:7], 1'b1, 0);
            chk(cyc_g == 178, "R4", "run length", cyc_g, 178);
            chk(done_g == 1, "R9", "done count", done_g, 1);
            chk(fmap[0] == VEC[v][6:1], "R7", "fault map", int'(fmap[0]), int'(VEC[v][6:1]));
            chk(ovf[0] == VEC[v][0], "R8", "overflow", int'(ovf[0]), int'(VEC[v][0]));
            held = fmap[0];
            repeat (4) @(negedge clk);
            chk(fmap[0] == held && !busy[0] && !done[0], "R9", "map held while idle",
                int'(fmap[0]), int'(held));
        end

        // start while busy is ignored
        run(0, 6'b001000, 1'b0, 20);
        chk(cyc_g == 178, "R2", "run length with start mid-run", cyc_g, 178);
        chk(fmap[0] == 6'b001000, "R2", "map with start mid-run", int'(fmap[0]), 8);
        repeat (3) @(negedge clk);
        chk(!busy[0], "R2", "no second run after mid-run start", int'(busy[0]), 0);

        // empty entries and other session sizes
        run(1, 6'b010000, 1'b0, 0);
        chk(first_g == 6'b000001, "R6", "leading empty entry skipped", int'(first_g), 1);
        chk(cyc_g == 219, "R6", "run length with empty entries", cyc_g, 219);
        chk(fmap[1] == 6'b010000, "R7", "fault map second table", int'(fmap[1]), 16);
        chk(!ovf[1], "R8", "no overflow at one fault", int'(ovf[1]), 0);

        // all-empty table
        run(2, 6'b000000, 1'b0, 0);
        chk(cyc_g == 2, "R6", "all-empty run length", cyc_g, 2);
        chk(fmap[2] == 6'b0 && !ovf[2], "R7", "all-empty map", int'(fmap[2]), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule